// File: doc/BRIEF.md
# Frozen-Leaf Validation Unit for Mixed Constituent Nodes

This unit decides, at run time, whether a constituent node of a successive-cancellation polar decoder that holds both frozen and information leaves can be decoded as if every leaf carried information. It takes the node's soft values and first makes a hard decision on each one. Because the polar transform is its own inverse, it then applies that transform to the hard-decision codeword to obtain the leaf bit estimates. Every leaf that the mask marks as frozen must come out as zero.

When every frozen leaf is zero, the hard-decision codeword is accepted as the node's result, and the decoder can skip the node's whole sub-tree. When any frozen leaf is one, the unit raises a one-cycle fallback request, and the surrounding decoder then traverses the node in the ordinary way. The unit handles node lengths from 1 up to `N_MAX` leaves, with the length given as a base-two logarithm. Two running counters, one for checks made and one for checks passed, let the surrounding logic or a bench measure the pass rate.

Top module: `fbc_unit`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it rises with no input, `done_o`, `pass_o` and `fallback_o` are 0, `codeword_o` and `leaf_o` are 0, and both counters are 0.
- R2: For node length n = 2^`node_log_i`, codeword bit i equals the sign bit (bit `LLR_W`-1) of LLR entry i, which occupies `llr_i[i*LLR_W +: LLR_W]`, for every i < n. Codeword bits at i >= n are 0.
- R3: `leaf_o` is the length-`N_MAX` polar butterfly of the codeword. Each stage s, for s from 0 to log2(`N_MAX`)-1, replaces bit i with bit i XOR bit i+2^s wherever bit s of i is 0.
- R4: `pass_o` is 1 exactly when every leaf i < n whose bit is set in `frozen_mask_i` has a leaf estimate of 0. An all-zero mask always passes.
- R5: `done_o` is 1 in the cycle after a cycle with `valid_i` high, and 0 otherwise. While `done_o` is 0, `codeword_o` and `leaf_o` hold their last values, and back-to-back inputs each produce their own result.
- R6: `fallback_o` is a one-cycle pulse that is high exactly when `done_o` is 1 and `pass_o` is 0.
- R7: `total_cnt_o` increments by one for each result, and `pass_cnt_o` increments by one for each passing result. Both counters wrap at `CNT_W` bits.
- R8: A `node_log_i` value above log2(`N_MAX`) is treated as the full length `N_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Node inputs are valid this cycle |
| llr_i | input | N_MAX*LLR_W | Signed LLRs, entry i at bits i*LLR_W upward |
| frozen_mask_i | input | N_MAX | Bit i set when leaf i is frozen |
| node_log_i | input | $clog2($clog2(N_MAX)+1) | log2 of node length |
| done_o | output | 1 | Result valid |
| pass_o | output | 1 | Frozen-leaf check succeeded |
| fallback_o | output | 1 | Request for ordinary traversal of the node |
| codeword_o | output | N_MAX | Hard-decision codeword of the node |
| leaf_o | output | N_MAX | Leaf bit estimates |
| pass_cnt_o | output | CNT_W | Passing checks |
| total_cnt_o | output | CNT_W | All checks |

## Verification
The bench builds leaf patterns with known frozen positions, then encodes them into LLR signs, so the expected leaf estimates are the chosen pattern itself. A unit that got the transform order or the stage partners wrong would return different leaves. Short nodes carry negative LLRs above their length. A unit that failed to mask the upper entries would show ones in the codeword, and could wrongly fail the check. Out-of-range length codes must behave as the full length, and a wrong clamp would truncate the node. Back-to-back inputs and idle cycles expose a unit that merges results, stretches the fallback pulse, or counts while idle.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned FBC_N_MAX_DEF = 16;
  localparam int unsigned FBC_LLR_W_DEF = 8;
  localparam int unsigned FBC_CNT_W_DEF = 16;

  typedef enum logic [1:0] {
    FBC_IDLE = 2'd0,
    FBC_PASS = 2'd1,
    FBC_FAIL = 2'd2
  } fbc_verdict_e;
endpackage

// File: rtl/fbc_hard_dec.sv
module fbc_hard_dec #(
  parameter int unsigned N     = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned LG    = 4,
  parameter int unsigned LOG_W = 3
) (
  input  logic [N*W-1:0]   llr_i,
  input  logic [LOG_W-1:0] node_log_i,
  output logic [N-1:0]     cw_o,
  output logic [N-1:0]     len_mask_o
);
  localparam int unsigned IDX_W = LG + 1;

  logic [LOG_W-1:0] eff_log;
  // out-of-range length codes clamp to the full node
  assign eff_log = (node_log_i > LOG_W'(LG)) ? LOG_W'(LG) : node_log_i;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign len_mask_o[i] = ((IDX_W'(i)) >> eff_log) == '0;
    assign cw_o[i]       = llr_i[i*W + W - 1] & len_mask_o[i];
  end
endmodule

// File: rtl/fbc_butterfly.sv
module fbc_butterfly #(
  parameter int unsigned N  = 16,
  parameter int unsigned LG = 4
) (
  input  logic [N-1:0] cw_i,
  output logic [N-1:0] leaf_o
);
  logic [LG:0][N-1:0] st;

  assign st[0] = cw_i;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i >> s) & 1) == 0) begin : g_xor
        assign st[s+1][i] = st[s][i] ^ st[s][i + (1 << s)];
      end else begin : g_pass
        assign st[s+1][i] = st[s][i];
      end
    end
  end

  assign leaf_o = st[LG];
endmodule

// File: rtl/fbc_frozen_test.sv
module fbc_frozen_test #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] leaf_i,
  input  logic [N-1:0] frozen_mask_i,
  input  logic [N-1:0] len_mask_i,
  output logic         pass_o
);
  logic [N-1:0] hit;

  assign hit    = leaf_i & frozen_mask_i & len_mask_i;
  assign pass_o = ~|hit;
endmodule

// File: rtl/fbc_count.sv
module fbc_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/fbc_unit.sv
module fbc_unit #(
  parameter int unsigned N_MAX = fbc_pkg::FBC_N_MAX_DEF,
  parameter int unsigned LLR_W = fbc_pkg::FBC_LLR_W_DEF,
  parameter int unsigned CNT_W = fbc_pkg::FBC_CNT_W_DEF,
  localparam int unsigned LG    = $clog2(N_MAX),
  localparam int unsigned LOG_W = $clog2(LG + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_MAX*LLR_W-1:0] llr_i,
  input  logic [N_MAX-1:0]   frozen_mask_i,
  input  logic [LOG_W-1:0]   node_log_i,
  output logic               done_o,
  output logic               pass_o,
  output logic               fallback_o,
  output logic [N_MAX-1:0]   codeword_o,
  output logic [N_MAX-1:0]   leaf_o,
  output logic [CNT_W-1:0]   pass_cnt_o,
  output logic [CNT_W-1:0]   total_cnt_o
);
  import fbc_pkg::*;

  logic [N_MAX-1:0] cw_d, len_mask_d, leaf_d;
  logic             pass_d;
  fbc_verdict_e     verdict_q;
  logic [N_MAX-1:0] cw_q, leaf_q;

  fbc_hard_dec #(.N(N_MAX), .W(LLR_W), .LG(LG), .LOG_W(LOG_W)) u_hd (
    .llr_i      (llr_i),
    .node_log_i (node_log_i),
    .cw_o       (cw_d),
    .len_mask_o (len_mask_d)
  );

  fbc_butterfly #(.N(N_MAX), .LG(LG)) u_bf (
    .cw_i   (cw_d),
    .leaf_o (leaf_d)
  );

  fbc_frozen_test #(.N(N_MAX)) u_ft (
    .leaf_i        (leaf_d),
    .frozen_mask_i (frozen_mask_i),
    .len_mask_i    (len_mask_d),
    .pass_o        (pass_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_q <= FBC_IDLE;
      cw_q      <= '0;
      leaf_q    <= '0;
    end else if (valid_i) begin
      verdict_q <= pass_d ? FBC_PASS : FBC_FAIL;
      cw_q      <= cw_d;
      leaf_q    <= leaf_d;
    end else begin
      verdict_q <= FBC_IDLE;
    end
  end

  fbc_count #(.W(CNT_W)) u_cnt_all (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (valid_i),
    .cnt_o  (total_cnt_o)
  );

  fbc_count #(.W(CNT_W)) u_cnt_pass (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (valid_i & pass_d),
    .cnt_o  (pass_cnt_o)
  );

  assign done_o     = verdict_q != FBC_IDLE;
  assign pass_o     = verdict_q == FBC_PASS;
  assign fallback_o = verdict_q == FBC_FAIL;
  assign codeword_o = cw_q;
  assign leaf_o     = leaf_q;
endmodule

// File: rtl/fbc_unit_chk.sv
module fbc_unit_chk #(
  parameter int unsigned N_MAX = 16,
  parameter int unsigned LLR_W = 8,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LOG_W = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [N_MAX*LLR_W-1:0] llr_i,
  input logic [N_MAX-1:0]       frozen_mask_i,
  input logic [LOG_W-1:0]       node_log_i,
  input logic                   done_o,
  input logic                   pass_o,
  input logic                   fallback_o,
  input logic [N_MAX-1:0]       codeword_o,
  input logic [N_MAX-1:0]       leaf_o,
  input logic [CNT_W-1:0]       pass_cnt_o,
  input logic [CNT_W-1:0]       total_cnt_o
);
  assert_done_after_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_no_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(codeword_o) && $stable(leaf_o)));
  assert_fallback_fail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |-> (done_o && !pass_o));
  assert_fail_raises_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> fallback_o);
  assert_fallback_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |=> (!fallback_o || $past(valid_i)));
  assert_pass_frozen_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> ((leaf_o & $past(frozen_mask_i)) == '0));
  assert_fail_frozen_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |-> ((leaf_o & $past(frozen_mask_i)) != '0));
  assert_total_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (total_cnt_o == CNT_W'($past(total_cnt_o) + 1'b1)));
  assert_total_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(total_cnt_o));
  assert_pass_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (pass_cnt_o == CNT_W'($past(pass_cnt_o) + 1'b1)));
  assert_pass_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_o |-> $stable(pass_cnt_o));
endmodule

bind fbc_unit fbc_unit_chk #(
  .N_MAX(N_MAX), .LLR_W(LLR_W), .CNT_W(CNT_W), .LOG_W(LOG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .llr_i(llr_i),
  .frozen_mask_i(frozen_mask_i), .node_log_i(node_log_i), .done_o(done_o),
  .pass_o(pass_o), .fallback_o(fallback_o), .codeword_o(codeword_o),
  .leaf_o(leaf_o), .pass_cnt_o(pass_cnt_o), .total_cnt_o(total_cnt_o)
);

// File: tb/sim_fbc_unit.sv
`timescale 1ns/1ps
module sim_fbc_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [127:0] llr = '0;
  logic [15:0]  mask = '0;
  logic [2:0]   nlog = '0;
  logic         done, pass, fb;
  logic [15:0]  cw, leaf, pcnt, tcnt;

  int n_chk = 0;
  int n_bad = 0;
  int e_tot = 0;
  int e_pas = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fbc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .llr_i(llr),
    .frozen_mask_i(mask), .node_log_i(nlog), .done_o(done), .pass_o(pass),
    .fallback_o(fb), .codeword_o(cw), .leaf_o(leaf),
    .pass_cnt_o(pcnt), .total_cnt_o(tcnt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // polar butterfly, self-inverse
  function automatic logic [15:0] xf(input logic [15:0] v);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 16; i++)
        if (((i >> s) & 1) == 0) v[i] = v[i] ^ v[i + (1 << s)];
    return v;
  endfunction

  // entries beyond n are negative so an unmasked design shows ones
  function automatic logic [127:0] mk_llr(input logic [15:0] c, input int n);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      logic signed [7:0] e;
      if (i >= n)    e = -8'sd9;
      else if (c[i]) e = 8'(-(3 + i));
      else           e = 8'(2 + i);
      r[i*8 +: 8] = e;
    end
    return r;
  endfunction

  task automatic check_res(input string req, input logic [15:0] e_cw,
                           input logic [15:0] e_leaf, input bit e_pass);
    e_tot++;
    if (e_pass) e_pas++;
    chk("R5", "done", 32'(done), 32'd1);
    chk(req, "pass", 32'(pass), 32'(e_pass));
    chk("R6", "fallback", 32'(fb), 32'(!e_pass));
    chk("R2", "codeword", 32'(cw), 32'(e_cw));
    chk("R3", "leaf", 32'(leaf), 32'(e_leaf));
    chk("R7", "total_cnt", 32'(tcnt), 32'(e_tot));
    chk("R7", "pass_cnt", 32'(pcnt), 32'(e_pas));
  endtask

  // drive one node from a chosen leaf pattern u (zero above n)
  task automatic run_u(input string req, input logic [15:0] u, input logic [15:0] m,
                       input logic [2:0] lg, input int n, input bit e_pass);
    logic [15:0] c;
    c = xf(u);
    @(negedge clk);
    llr = mk_llr(c, n); mask = m; nlog = lg; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check_res(req, c, u, e_pass);
  endtask

  task automatic test_reset();
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "pass/fb", 32'({pass, fb}), 32'd0);
    chk("R1", "cw/leaf", 32'({cw, leaf}), 32'd0);
    chk("R1", "counters", 32'({pcnt, tcnt}), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", 32'(done), 32'd0);
    chk("R1", "counters after release", 32'({pcnt, tcnt}), 32'd0);
  endtask

  task automatic test_all_info();
    logic [15:0] c;
    c = 16'h5A3C;
    @(negedge clk);
    llr = mk_llr(c, 16); mask = 16'h0000; nlog = 3'd4; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check_res("R4", c, xf(c), 1'b1);
  endtask

  task automatic test_pass_fail_full();
    logic [15:0] m;
    m = 16'h0F17;
    run_u("R4", 16'hA5E8 & ~m, m, 3'd4, 16, 1'b1);
    run_u("R4", (16'hA5E8 & ~m) | 16'h0004, m, 3'd4, 16, 1'b0);
    run_u("R4", 16'h0800, m, 3'd4, 16, 1'b0);
  endtask

  task automatic test_lengths();
    for (int lg = 0; lg < 4; lg++) begin
      int n;
      logic [15:0] full;
      n = 1 << lg;
      full = 16'((1 << n) - 1);
      run_u("R2", full & ~16'h0001, 16'h0001, 3'(lg), n, 1'b1);
      run_u("R4", 16'h0001, 16'h0001, 3'(lg), n, 1'b0);
    end
    // mask bits above the length are ignored
    run_u("R4", 16'h0006, 16'hFFF1, 3'd2, 4, 1'b1);
  endtask

  task automatic test_clamp();
    run_u("R8", 16'hC300, 16'h00FF, 3'd5, 16, 1'b1);
    run_u("R8", 16'h8001, 16'h00FF, 3'd7, 16, 1'b0);
  endtask

  task automatic test_idle();
    logic [15:0] cw0, lf0;
    cw0 = cw; lf0 = leaf;
    @(negedge clk);
    llr = '1; mask = '1; nlog = 3'd4;
    @(negedge clk);
    chk("R5", "idle done", 32'(done), 32'd0);
    chk("R6", "idle fallback", 32'(fb), 32'd0);
    chk("R5", "idle hold", 32'({cw, leaf}), 32'({cw0, lf0}));
    chk("R7", "idle total", 32'(tcnt), 32'(e_tot));
  endtask

  task automatic test_back_to_back();
    logic [15:0] ua, ub;
    ua = 16'h00F0; ub = 16'h0001;
    @(negedge clk);
    llr = mk_llr(xf(ua), 16); mask = 16'h000F; nlog = 3'd4; valid = 1'b1;
    @(negedge clk);
    llr = mk_llr(xf(ub), 16);
    check_res("R5", xf(ua), ua, 1'b1);
    @(negedge clk);
    valid = 1'b0;
    check_res("R5", xf(ub), ub, 1'b0);
    @(negedge clk);
    chk("R6", "fallback single cycle", 32'(fb), 32'd0);
  endtask

  initial begin
    test_reset();
    test_all_info();
    test_pass_fail_full();
    test_lengths();
    test_clamp();
    test_idle();
    test_back_to_back();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule